// File: doc/BRIEF.md
# Serial Register Port with Pipelined Readback

This block is a serial slave that lets a host processor configure and read a small bank of 16-bit registers over a four-wire SPI bus in mode 3. Every bus transaction is one 16-bit frame, sent most significant bit first. The frame holds a direction flag, a 7-bit byte address and one data byte. A write frame changes exactly one byte of one register. A read frame only names a register. The whole 16-bit word then comes back on MISO during the next frame, and that next frame may itself carry the following read request. This lets the host poll a location back to back.

All bus pins are sampled by a system clock at least eight times faster than SCLK, through two-flop synchronizers. The bank holds a set of read/write configuration words, a read-only sample word fed from an input port, and a write-only command word. In the command word, one bit produces a single-cycle capture-start pulse at the end of the frame that sets it.

Top module: `spi_regbank_slave`

## Requirements
- R1: A frame is 16 bits, shifted in MSB first, with MOSI sampled on rising SCLK while CS is low. Bit 15 is the direction (1 = write, 0 = read), bits 14:8 are the byte address, and bits 7:0 are the data byte.
- R2: Configuration word i sits at byte addresses CFG_BASE+2i (lower byte) and CFG_BASE+2i+1 (upper byte). A write changes only the addressed byte and leaves the other byte as it was.
- R3: A write becomes visible on `cfg_o` at the fourth rising system-clock edge after the 16th rising SCLK edge appears at the pin. Configuration outputs change at no other time.
- R4: After a complete read frame, the next frame shifts the full 16-bit word out on MISO, MSB first. The word is captured when CS falls. Either byte address of a word returns the whole word.
- R5: The data byte of a read frame has no effect. A frame that returns read data may carry a new read request, so reads can be chained.
- R6: MISO shows the MSB from CS fall and moves to the next bit after each falling SCLK edge except the first of the frame. After a write frame, or after reset, the next frame shifts out all zeros. MISO does not change while CS is high.
- R7: Writing the upper byte of the command word (byte address 0x3F) with data bit 3 set (word bit 11) raises `cap_start_o` for exactly one system clock, in the same cycle a register write would land. Nothing stays set, and reads of 0x3E/0x3F return zero.
- R8: Byte addresses 0x14/0x15 read `sample_i`, for example 0xF9DA. Writes to them are ignored.
- R9: If CS rises before 16 bits have arrived, the partial frame is dropped. No write happens, and a read request pending from an earlier frame stays pending.
- R10: Reads of unmapped addresses return zero. Writes to them change nothing.
- R11: Reset (synchronous, active low) clears all configuration words, `cap_start_o` and MISO, and leaves no read pending.
- R12: SCLK edges after the 16th in a frame are ignored until CS rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high |
| cs_n_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| sample_i | input | 16 | Signed sample value shown at 0x14/0x15 |
| cfg_o | output | 16*NUM_CFG | Configuration words, word i at bits 16i+15:16i |
| cap_start_o | output | 1 | One-cycle capture-start pulse |

## Verification
Two events can land in the same frame: shifting out a word that an earlier request asked for, and latching a new read request or applying a write. The bench provokes this with chained reads, with a write sent while a readback is in flight, and with a capture command sent just after a read request. It judges the outcome by comparing every MISO bit against a behavioural model that captures the returned word at CS fall. In parallel, `cfg_o` and `cap_start_o` are compared with the model on every clock, so a write or pulse that lands in the wrong cycle is caught.

// File: rtl/spireg_pkg.sv
// Shared widths and the frame layout for the serial register port.
package spireg_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int FRAME_W = 1 + ADDR_W + BYTE_W;

    // One received frame: direction flag, byte address, data byte.
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/spireg_sync.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes every bit is independent; reset value is given per bit.
module spireg_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    // Two register stages to settle metastable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/spireg_rx.sv
// Frame receiver: finds SCLK/CS edges on synchronized inputs, shifts MOSI in
// on rising SCLK and flags a complete frame for one cycle on the 16th bit.
// Assumes the inputs come from spireg_sync and SCLK is slow against clk.
module spireg_rx
    import spireg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sclk_s,
    input  logic   cs_s,
    input  logic   mosi_s,
    output logic   done_o,
    output frame_t frame_o,
    output logic   cs_fall_o,
    output logic   shift_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic               sclk_d;
    logic               cs_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] rx_sh;
    logic [FRAME_W-1:0] rx_next;
    logic               sclk_rise;
    logic               sclk_fall;

    assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
    assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
    assign rx_next   = {rx_sh[FRAME_W-2:0], mosi_s};
    assign cs_fall_o = ~cs_s & cs_d;
    assign shift_o   = sclk_fall & (bit_cnt != '0);

    // Keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    // Shift bits in, count them and publish a frame on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            done_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (cs_s) begin
                bit_cnt <= '0;
            end else if (sclk_rise && bit_cnt != CNT_FULL) begin
                rx_sh   <= rx_next;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_LAST) begin
                    done_o  <= 1'b1;
                    frame_o <= frame_t'(rx_next);
                end
            end
        end
    end
endmodule

// File: rtl/spireg_tx.sv
// Readback shifter: loads a word when CS falls and moves to the next bit on
// each qualified falling SCLK edge. MISO is the register MSB.
module spireg_tx
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              miso_o
);
    logic [WORD_W-1:0] tx_sh;

    // Load at frame start, shift towards the MSB on falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load_i) begin
            tx_sh <= word_i;
        end else if (shift_i) begin
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
    end

    assign miso_o = tx_sh[WORD_W-1];
endmodule

// File: rtl/spireg_regs.sv
// Register bank: byte writes into configuration words, read-only sample word,
// write-only command bit turned into a pulse, and the pending read request.
// Assumes done_i is a single-cycle strobe with frame_i valid alongside it.
module spireg_regs
    import spireg_pkg::*;
#(
    parameter int                NUM_CFG     = 4,
    parameter logic [ADDR_W-1:0] CFG_BASE    = 7'h20,
    parameter logic [ADDR_W-1:0] SAMPLE_ADDR = 7'h14,
    parameter logic [ADDR_W-1:0] CMD_ADDR    = 7'h3E,
    parameter int                CAP_BIT     = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      done_i,
    input  frame_t                    frame_i,
    input  logic [WORD_W-1:0]         sample_i,
    output logic [NUM_CFG*WORD_W-1:0] cfg_o,
    output logic                      cap_start_o,
    output logic [WORD_W-1:0]         rd_word_o
);
    localparam int WA_W = ADDR_W - 1;
    localparam logic [WA_W-1:0] CFG_WBASE  = CFG_BASE[ADDR_W-1:1];
    localparam logic [WA_W-1:0] SAMPLE_WA  = SAMPLE_ADDR[ADDR_W-1:1];
    localparam logic [WA_W-1:0] CMD_WA     = CMD_ADDR[ADDR_W-1:1];
    localparam logic            CAP_HI     = (CAP_BIT >= BYTE_W);
    localparam int              CAP_DBIT   = CAP_BIT % BYTE_W;
    localparam logic [ADDR_W-1:0] CAP_BADDR = {CMD_WA, CAP_HI};

    logic            wr_stb;
    logic            pend_v;
    logic [ADDR_W-1:0] pend_a;

    assign wr_stb = done_i & frame_i.wr;

    // One storage word per configuration slot, written a byte at a time.
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam logic [WA_W-1:0] WA = CFG_WBASE + WA_W'(g);
        logic [WORD_W-1:0] word_q;

        // Update the addressed byte of this word on a write frame.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_stb && frame_i.addr[ADDR_W-1:1] == WA) begin
                if (frame_i.addr[0]) begin
                    word_q[WORD_W-1:BYTE_W] <= frame_i.data;
                end else begin
                    word_q[BYTE_W-1:0] <= frame_i.data;
                end
            end
        end

        assign cfg_o[g*WORD_W +: WORD_W] = word_q;
    end

    // Fire the capture pulse for one cycle; the command bit is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_start_o <= 1'b0;
        end else begin
            cap_start_o <= wr_stb && (frame_i.addr == CAP_BADDR)
                           && frame_i.data[CAP_DBIT];
        end
    end

    // Each completed frame replaces the pending read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_a <= '0;
        end else if (done_i) begin
            pend_v <= ~frame_i.wr;
            pend_a <= frame_i.addr;
        end
    end

    // Select the word the pending request names; unmapped reads give zero.
    always_comb begin
        rd_word_o = '0;
        if (pend_v) begin
            if (pend_a[ADDR_W-1:1] == SAMPLE_WA) begin
                rd_word_o = sample_i;
            end
            for (int i = 0; i < NUM_CFG; i++) begin
                if (pend_a[ADDR_W-1:1] == CFG_WBASE + WA_W'(i)) begin
                    rd_word_o = cfg_o[i*WORD_W +: WORD_W];
                end
            end
        end
    end
endmodule

// File: rtl/spi_regbank_slave.sv
// Top level of the serial register port: synchronizers, frame receiver,
// readback shifter and register bank. Assumes clk is at least 8x SCLK and
// that the host uses mode 3 with 16-bit frames.
module spi_regbank_slave
    import spireg_pkg::*;
#(
    parameter int                NUM_CFG     = 4,
    parameter logic [ADDR_W-1:0] CFG_BASE    = 7'h20,
    parameter logic [ADDR_W-1:0] SAMPLE_ADDR = 7'h14,
    parameter logic [ADDR_W-1:0] CMD_ADDR    = 7'h3E,
    parameter int                CAP_BIT     = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sclk_i,
    input  logic                      cs_n_i,
    input  logic                      mosi_i,
    output logic                      miso_o,
    input  logic [15:0]               sample_i,
    output logic [NUM_CFG*16-1:0]     cfg_o,
    output logic                      cap_start_o
);
    logic [2:0]        pins_s;
    logic              sclk_s;
    logic              cs_s;
    logic              mosi_s;
    logic              frm_done;
    frame_t            frm;
    logic              cs_fall;
    logic              tx_shift;
    logic [WORD_W-1:0] rd_word;

    spireg_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk_i, cs_n_i, mosi_i}),
        .q_o   (pins_s)
    );

    assign {sclk_s, cs_s, mosi_s} = pins_s;

    spireg_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .done_o    (frm_done),
        .frame_o   (frm),
        .cs_fall_o (cs_fall),
        .shift_o   (tx_shift)
    );

    spireg_regs #(
        .NUM_CFG     (NUM_CFG),
        .CFG_BASE    (CFG_BASE),
        .SAMPLE_ADDR (SAMPLE_ADDR),
        .CMD_ADDR    (CMD_ADDR),
        .CAP_BIT     (CAP_BIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (frm_done),
        .frame_i     (frm),
        .sample_i    (sample_i),
        .cfg_o       (cfg_o),
        .cap_start_o (cap_start_o),
        .rd_word_o   (rd_word)
    );

    spireg_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cs_fall),
        .shift_i (tx_shift),
        .word_i  (rd_word),
        .miso_o  (miso_o)
    );
endmodule

// File: rtl/spireg_checker.sv
// Protocol checks for spi_regbank_slave, bound into every instance.
module spireg_checker #(
    parameter int NUM_CFG = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_s,
    input logic                  done,
    input logic                  frame_wr,
    input logic                  frame_a0,
    input logic [NUM_CFG*16-1:0] cfg_o,
    input logic                  cap_start_o,
    input logic                  miso_o
);
    logic [NUM_CFG*8-1:0] lo_bytes;
    logic [NUM_CFG*8-1:0] hi_bytes;

    // Split the configuration words into their byte lanes.
    always_comb begin
        for (int i = 0; i < NUM_CFG; i++) begin
            lo_bytes[i*8 +: 8] = cfg_o[i*16 +: 8];
            hi_bytes[i*8 +: 8] = cfg_o[i*16+8 +: 8];
        end
    end

    a_r7_cap_single: assert property (@(posedge clk) disable iff (!rst_n)
        cap_start_o |=> !cap_start_o);

    a_r7_cap_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        cap_start_o |-> $past(done && frame_wr));

    a_r3_cfg_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(done && frame_wr));

    a_r2_odd_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_wr && frame_a0) |=> $stable(lo_bytes));

    a_r2_even_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_wr && !frame_a0) |=> $stable(hi_bytes));

    a_r6_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> $stable(miso_o));
endmodule

bind spi_regbank_slave spireg_checker #(.NUM_CFG(NUM_CFG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .done        (frm_done),
    .frame_wr    (frm.wr),
    .frame_a0    (frm.addr[0]),
    .cfg_o       (cfg_o),
    .cap_start_o (cap_start_o),
    .miso_o      (miso_o)
);

// File: tb/spi_regbank_slave_tb.sv
module spi_regbank_slave_tb;
    localparam int NUM_CFG = 4;
    localparam int HALF    = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  sclk = 1'b1;
    logic                  cs_n = 1'b1;
    logic                  mosi = 1'b0;
    logic                  miso;
    logic [15:0]           sample = 16'hF9DA;
    logic [NUM_CFG*16-1:0] cfg;
    logic                  cap;

    int n_cmp = 0;
    int n_bad = 0;
    int n_pulses = 0;
    bit run_cmp = 0;

    logic [15:0] m_cfg [NUM_CFG];
    bit          m_pend_v = 0;
    logic [6:0]  m_pend_a = '0;
    bit          m_cap = 0;

    always #2 clk = ~clk;

    spi_regbank_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .cs_n_i      (cs_n),
        .mosi_i      (mosi),
        .miso_o      (miso),
        .sample_i    (sample),
        .cfg_o       (cfg),
        .cap_start_o (cap)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] m_read(input logic [6:0] a);
        logic [15:0] r = '0;
        if (a[6:1] == 6'h0A) r = sample;
        for (int i = 0; i < NUM_CFG; i++)
            if (a[6:1] == 6'h10 + 6'(i)) r = m_cfg[i];
        return r;
    endfunction

    // Model of one completed frame, applied in the cycle the write lands.
    task automatic m_apply(input logic [15:0] f);
        if (f[15]) begin
            m_pend_v = 0;
            for (int i = 0; i < NUM_CFG; i++) begin
                if (f[14:9] == 6'h10 + 6'(i)) begin
                    if (f[8]) m_cfg[i][15:8] = f[7:0];
                    else      m_cfg[i][7:0]  = f[7:0];
                end
            end
            if (f[14:8] == 7'h3F && f[3]) m_cap = 1;
        end else begin
            m_pend_v = 1;
            m_pend_a = f[14:8];
        end
    endtask

    // Per-clock comparison of the outputs against the model (R3, R7, R2, R10).
    always @(negedge clk) begin
        if (run_cmp) begin
            logic [NUM_CFG*16-1:0] e;
            for (int i = 0; i < NUM_CFG; i++) e[i*16 +: 16] = m_cfg[i];
            check(cfg == e, "R3 cfg_o per clock", 64'(cfg), 64'(e));
            check(cap == m_cap, "R7 cap_start_o per clock", 64'(cap), 64'(m_cap));
            if (cap) n_pulses++;
        end
    end

    // Send one frame of nbits; each MISO bit is checked against the model.
    task automatic send(input logic [15:0] f, input int nbits, input string tag);
        logic [15:0] exp_tx;
        exp_tx = m_pend_v ? m_read(m_pend_a) : 16'h0000;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = (i < 16) ? f[15-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (i < 16)
                check(miso == exp_tx[15-i], tag, 64'(miso), 64'(exp_tx[15-i]));
            sclk = 1'b1;
            if (i == 15) begin
                fork
                    begin
                        repeat (4) @(posedge clk);
                        #1 m_apply(f);
                        @(posedge clk);
                        #1 m_cap = 0;
                    end
                join_none
            end
            repeat (HALF) @(negedge clk);
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    initial begin
        int p0;
        for (int i = 0; i < NUM_CFG; i++) m_cfg[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(cfg == '0, "R11 cfg after reset", 64'(cfg), 64'h0);
        check(cap == 1'b0, "R11 cap after reset", 64'(cap), 64'h0);
        check(miso == 1'b0, "R11 miso after reset", 64'(miso), 64'h0);
        run_cmp = 1;

        // R1, R2: byte writes into configuration word 0; R6 zeros after reset
        send(16'hA15A, 16, "R6 zeros with nothing pending");
        send(16'hA03C, 16, "R6 zeros after write");
        // R5: read request with nonzero data byte, then chained reads (R4)
        send(16'h20FF, 16, "R6 zeros after write");
        send(16'h2100, 16, "R5 readback of 0x20 ignores data byte");
        send(16'h1400, 16, "R4 odd address returns whole word");
        send(16'h0000, 16, "R8 sample readback 0xF9DA");
        // R8: write to the sample word is ignored
        send(16'h9411, 16, "R4 unmapped read returns zero");
        send(16'h1500, 16, "R6 zeros after write");
        sample = 16'h0123;
        send(16'h1400, 16, "R8 sample via odd address");
        send(16'h1400, 16, "R8 sample via even address");
        // R7: capture command, issued while a readback is in flight
        p0 = n_pulses;
        send(16'hBF08, 16, "R8 sample readback before command");
        check(n_pulses == p0 + 1, "R7 one pulse for 0xBF08", 64'(n_pulses - p0), 64'd1);
        send(16'h3F00, 16, "R6 zeros after command write");
        send(16'h3E00, 16, "R7 command word reads zero");
        send(16'h2200, 16, "R7 command word reads zero");
        p0 = n_pulses;
        send(16'hBF00, 16, "R4 readback of word 1");
        check(n_pulses == p0, "R7 no pulse without bit 3", 64'(n_pulses - p0), 64'd0);
        send(16'hBEFF, 16, "R6 zeros after write");
        check(n_pulses == p0, "R7 lower command byte no pulse", 64'(n_pulses - p0), 64'd0);
        // R9: partial frames drop, pending request survives
        send(16'hA277, 16, "R6 zeros after write");
        send(16'h2200, 16, "R6 zeros after write");
        send(16'hA3EE, 10, "R9 partial frame");
        send(16'hA2EE, 15, "R9 partial frame");
        send(16'h2300, 16, "R9 pending read survives partial frames");
        // R10: unmapped write and read
        send(16'hF0AA, 16, "R4 readback of word 1 via odd");
        send(16'h7000, 16, "R6 zeros after write");
        send(16'h2000, 16, "R10 unmapped read is zero");
        // R12: extra clocks after the 16th bit
        send(16'hA3C3, 20, "R4 readback of word 0");
        send(16'h2300, 16, "R12 zeros after long write frame");
        send(16'h2600, 16, "R12 word 1 after long frame");
        send(16'hA7D4, 16, "R4 readback of word 3");
        send(16'h2700, 16, "R6 zeros after write");
        send(16'h0000, 16, "R2 word 3 upper byte only");

        run_cmp = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule